// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit with HI/LO Accumulator

This block is the multiply unit of a 32-bit integer core. It holds a 64-bit accumulator. The accumulator is split into a HI word (upper 32 bits) and a LO word (lower 32 bits). The issue logic hands the block one operation per accepted cycle, together with two source operands, `rs_val` and `rt_val`. An operation is one of the following:

- a multiply that replaces the accumulator;
- a multiply that adds its product to the accumulator;
- a multiply that subtracts its product from the accumulator;
- a register-destination multiply;
- a move from HI or from LO;
- a move into HI or into LO.

The register-destination multiply and the moves from HI/LO deliver their result on a single register-write port, `rd_valid`/`rd_data`.

Latency is chosen per operation from the significant width of `rt_val`. An `rt_val` that fits in a half word gives the short timing. Any other `rt_val` gives the long timing. The `issue_ready` output tells the issue logic whether an operation offered this cycle is taken at the coming edge. `busy` marks the extra cycle that a long multiply holds the unit. `done` marks the cycle in which a multiply result has just become visible.

Top module: `mac_hilo_unit`

## Requirements
- R1: Operation codes 0 (signed) and 1 (unsigned) replace {HI,LO} with the 64-bit product of `rs_val` and `rt_val`. HI receives bits 63:32 and LO receives bits 31:0. The signed form sign-extends both operands and the unsigned form zero-extends them.
- R2: Codes 2 (signed) and 3 (unsigned) add the product to {HI,LO}. Codes 4 (signed) and 5 (unsigned) subtract the product from {HI,LO}. Both wrap modulo 2^64.
- R3: Code 6 places bits 31:0 of the signed product on `rd_data`, with `rd_valid` high, and leaves HI and LO unchanged.
- R4: Code 8 (read HI) and code 9 (read LO) drive the register value on `rd_data`, with `rd_valid` high for exactly one cycle, in the cycle right after the accepting edge.
- R5: Code 10 writes `rs_val` into HI and code 11 writes `rs_val` into LO. The other word is left unchanged.
- R6: `rt_val` is narrow when its bits 31:15 are all equal (signed codes) or when its bits 31:16 are all zero (unsigned codes). Otherwise it is wide.
- R7: An accumulator multiply (codes 0 to 5) with a narrow `rt_val` raises `done` in the cycle after acceptance and allows a new issue at the next edge. With a wide `rt_val`, `done` rises two cycles after acceptance and `busy` is high for the one cycle in between, during which nothing is accepted.
- R8: Code 6 with a narrow `rt_val` shows its result (with `done`) two cycles after acceptance and does not block the next issue. With a wide `rt_val`, the result appears three cycles after acceptance and `busy` is high for the first cycle after acceptance.
- R9: While a code-6 result is still pending, `issue_ready` is low for codes 8 and 9. Such a read is taken at the first edge after the pending result has been written.
- R10: After reset, HI and LO read as zero and `busy`, `done` and `rd_valid` are low.
- R11: Codes 7, 12, 13, 14 and 15 are accepted and change neither HI, LO, `rd_valid` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_op | input | 4 | Operation code (see requirements) |
| rs_val | input | DATA_W | First source operand |
| rt_val | input | DATA_W | Second source operand; its width selects the latency |
| issue_ready | output | 1 | The offered operation is taken at the coming edge |
| busy | output | 1 | A long multiply holds the unit this cycle |
| done | output | 1 | A multiply result became visible this cycle |
| rd_valid | output | 1 | `rd_data` carries a register write this cycle |
| rd_data | output | DATA_W | Register-write data |

## Verification
The bench builds the unit with its default 32-bit data width and 16-bit narrow threshold. Under these values the classification edges can be reached directly: 0x7FFF, 0x8000, 0xFFFF8000 and 0xFFFF7FFF under both signed and unsigned codes. The full 64-bit wrap of subtract and unsigned all-ones products can also be reached. A behavioural model predicts `issue_ready`, `busy`, `done`, `rd_valid` and `rd_data` every cycle. This covers back-to-back narrow and wide register multiplies followed immediately by HI/LO reads, which is where the read stall and the sharing of the register-write port matter.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Operation codes presented on issue_op
    localparam logic [3:0] OP_MULT  = 4'd0;
    localparam logic [3:0] OP_MULTU = 4'd1;
    localparam logic [3:0] OP_MADD  = 4'd2;
    localparam logic [3:0] OP_MADDU = 4'd3;
    localparam logic [3:0] OP_MSUB  = 4'd4;
    localparam logic [3:0] OP_MSUBU = 4'd5;
    localparam logic [3:0] OP_MUL   = 4'd6;
    localparam logic [3:0] OP_RDHI  = 4'd8;
    localparam logic [3:0] OP_RDLO  = 4'd9;
    localparam logic [3:0] OP_WRHI  = 4'd10;
    localparam logic [3:0] OP_WRLO  = 4'd11;

    // Latencies of the operations that go through the pending slot
    localparam int unsigned LAT_ACC_WIDE  = 2;
    localparam int unsigned LAT_REG_SHORT = 2;
    localparam int unsigned LAT_REG_LONG  = 3;
    localparam int unsigned SLOT_CNT_W    = $clog2(LAT_REG_LONG);

    typedef enum logic [1:0] {
        ACC_SET = 2'd0,
        ACC_ADD = 2'd1,
        ACC_SUB = 2'd2
    } acc_mode_e;

    typedef struct packed {
        logic      acc_mult;   // result goes to {HI,LO}
        logic      reg_mult;   // result goes to the register-write port
        acc_mode_e mode;
        logic      sgn;
        logic      rd_hi;
        logic      rd_lo;
        logic      wr_hi;
        logic      wr_lo;
    } op_info_t;

    function automatic op_info_t decode_op(input logic [3:0] code);
        op_info_t d;
        d = '0;
        d.mode = ACC_SET;
        case (code)
            OP_MULT:  begin d.acc_mult = 1'b1; d.sgn = 1'b1; end
            OP_MULTU: begin d.acc_mult = 1'b1; end
            OP_MADD:  begin d.acc_mult = 1'b1; d.sgn = 1'b1; d.mode = ACC_ADD; end
            OP_MADDU: begin d.acc_mult = 1'b1; d.mode = ACC_ADD; end
            OP_MSUB:  begin d.acc_mult = 1'b1; d.sgn = 1'b1; d.mode = ACC_SUB; end
            OP_MSUBU: begin d.acc_mult = 1'b1; d.mode = ACC_SUB; end
            OP_MUL:   begin d.reg_mult = 1'b1; d.sgn = 1'b1; end
            OP_RDHI:  d.rd_hi = 1'b1;
            OP_RDLO:  d.rd_lo = 1'b1;
            OP_WRHI:  d.wr_hi = 1'b1;
            OP_WRLO:  d.wr_lo = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mac_width_class.sv
module mac_width_class #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic [DATA_W-1:0] rt_val,
    input  logic              sgn,
    output logic              narrow
);
    // Bits that must be pure sign copies (signed) or zero (unsigned)
    localparam int unsigned SIGN_SPAN = DATA_W - NARROW_W + 1;

    logic [SIGN_SPAN-1:0] sign_part;
    logic [SIGN_SPAN-2:0] zero_part;

    assign sign_part = rt_val[DATA_W-1:NARROW_W-1];
    assign zero_part = rt_val[DATA_W-1:NARROW_W];

    always_comb begin
        if (sgn) begin
            narrow = (&sign_part) | ~(|sign_part);
        end else begin
            narrow = ~(|zero_part);
        end
    end
endmodule

// File: rtl/mac_issue_ctrl.sv
module mac_issue_ctrl
    import mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue_valid,
    input  op_info_t info,
    input  logic     narrow,
    output logic     issue_ready,
    output logic     accept,
    output logic     busy,
    output logic     done,
    output logic     slot_load,
    output logic     slot_retire,
    output logic     direct_acc
);
    localparam logic [SLOT_CNT_W-1:0] CNT_ACC_WIDE  = SLOT_CNT_W'(LAT_ACC_WIDE - 1);
    localparam logic [SLOT_CNT_W-1:0] CNT_REG_SHORT = SLOT_CNT_W'(LAT_REG_SHORT - 1);
    localparam logic [SLOT_CNT_W-1:0] CNT_REG_LONG  = SLOT_CNT_W'(LAT_REG_LONG - 1);
    localparam logic [SLOT_CNT_W-1:0] CNT_ONE       = SLOT_CNT_W'(1);

    logic                  busy_q;
    logic                  done_q;
    logic                  slot_valid_q;
    logic [SLOT_CNT_W-1:0] slot_cnt_q;
    logic                  is_mult;
    logic                  is_read;
    logic [SLOT_CNT_W-1:0] load_cnt;

    assign is_mult     = info.acc_mult | info.reg_mult;
    assign is_read     = info.rd_hi | info.rd_lo;
    assign issue_ready = ~busy_q & ~(is_read & slot_valid_q);
    assign accept      = issue_valid & issue_ready;
    assign slot_retire = slot_valid_q & (slot_cnt_q == CNT_ONE);
    assign direct_acc  = accept & info.acc_mult & narrow;
    assign slot_load   = accept & (info.reg_mult | (info.acc_mult & ~narrow));
    assign busy        = busy_q;
    assign done        = done_q;

    always_comb begin
        if (info.reg_mult) begin
            load_cnt = narrow ? CNT_REG_SHORT : CNT_REG_LONG;
        end else begin
            load_cnt = CNT_ACC_WIDE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            slot_valid_q <= 1'b0;
            slot_cnt_q   <= '0;
        end else begin
            busy_q <= accept & is_mult & ~narrow;
            done_q <= direct_acc | slot_retire;
            if (slot_load) begin
                slot_valid_q <= 1'b1;
                slot_cnt_q   <= load_cnt;
            end else if (slot_retire) begin
                slot_valid_q <= 1'b0;
                slot_cnt_q   <= '0;
            end else if (slot_valid_q) begin
                slot_cnt_q <= slot_cnt_q - CNT_ONE;
            end
        end
    end

    AST_BUSY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !busy_q); // R7

    AST_WIDE_REPEAT_TWO: assert property (@(posedge clk) disable iff (rst)
        (accept && is_mult && !narrow) |=> !accept); // R8

    AST_SLOT_FREE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        slot_load |-> (!slot_valid_q || slot_retire)); // R8
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  op_info_t          info,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic              accept,
    input  logic              direct_acc,
    input  logic              slot_load,
    input  logic              slot_retire,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;
    logic [PROD_W-1:0] slot_prod_q;
    op_info_t          slot_info_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] acc;

    function automatic logic [PROD_W-1:0] extend(input logic [DATA_W-1:0] v,
                                                 input logic sgn);
        return sgn ? {{DATA_W{v[DATA_W-1]}}, v} : {{DATA_W{1'b0}}, v};
    endfunction

    function automatic logic [PROD_W-1:0] combine(input logic [PROD_W-1:0] a,
                                                  input logic [PROD_W-1:0] p,
                                                  input acc_mode_e m);
        case (m)
            ACC_ADD: return a + p;
            ACC_SUB: return a - p;
            default: return p;
        endcase
    endfunction

    assign prod     = extend(rs_val, info.sgn) * extend(rt_val, info.sgn);
    assign acc      = {hi_q, lo_q};
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q        <= '0;
            lo_q        <= '0;
            slot_prod_q <= '0;
            slot_info_q <= '0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            if (slot_load) begin
                slot_prod_q <= prod;
                slot_info_q <= info;
            end
            if (slot_retire) begin
                if (slot_info_q.reg_mult) begin
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= slot_prod_q[DATA_W-1:0];
                end else begin
                    {hi_q, lo_q} <= combine(acc, slot_prod_q, slot_info_q.mode);
                end
            end
            if (direct_acc) begin
                {hi_q, lo_q} <= combine(acc, prod, info.mode);
            end
            if (accept && info.wr_hi) begin
                hi_q <= rs_val;
            end
            if (accept && info.wr_lo) begin
                lo_q <= rs_val;
            end
            if (accept && (info.rd_hi || info.rd_lo)) begin
                rd_valid_q <= 1'b1;
                rd_data_q  <= info.rd_hi ? hi_q : lo_q;
            end
        end
    end

    AST_RD_PORT_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(slot_retire && slot_info_q.reg_mult &&
          accept && (info.rd_hi || info.rd_lo))); // R9

    AST_ACC_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(slot_retire && !slot_info_q.reg_mult &&
          (direct_acc || (accept && (info.wr_hi || info.wr_lo))))); // R7

    AST_REG_MULT_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (slot_retire && slot_info_q.reg_mult && !accept) |=> $stable({hi_q, lo_q})); // R3
endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [3:0]        issue_op,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              issue_ready,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    op_info_t info;
    logic     narrow;
    logic     accept;
    logic     slot_load;
    logic     slot_retire;
    logic     direct_acc;

    assign info = decode_op(issue_op);

    mac_width_class #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_class (
        .rt_val (rt_val),
        .sgn    (info.sgn),
        .narrow (narrow)
    );

    mac_issue_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .info        (info),
        .narrow      (narrow),
        .issue_ready (issue_ready),
        .accept      (accept),
        .busy        (busy),
        .done        (done),
        .slot_load   (slot_load),
        .slot_retire (slot_retire),
        .direct_acc  (direct_acc)
    );

    mac_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst         (rst),
        .info        (info),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .accept      (accept),
        .direct_acc  (direct_acc),
        .slot_load   (slot_load),
        .slot_retire (slot_retire),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    AST_DONE_NOT_WITH_READ: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && (issue_op == OP_RDHI || issue_op == OP_RDLO))
        |=> !done); // R4
endmodule

// File: tb/tb_mac_hilo_unit.sv
module tb_mac_hilo_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [3:0]  issue_op;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic        issue_ready;
    logic        busy;
    logic        done;
    logic        rd_valid;
    logic [31:0] rd_data;

    always #4 clk = ~clk;   // 125 MHz

    mac_hilo_unit #(.DATA_W(32), .NARROW_W(16)) dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .rs_val(rs_val), .rt_val(rt_val), .issue_ready(issue_ready),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Behavioural reference model
    logic [63:0] m_acc;
    int          edge_n;
    int          block_edge;
    int          pend_edge;
    bit          exp_done[int];
    logic [31:0] exp_rd[int];
    int          n_chk;
    int          n_err;
    string       cur_req;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_narrow(input logic [31:0] v, input bit sgn);
        if (sgn) return ($signed(v) >= -32768) && ($signed(v) <= 32767);
        return v < 32'h0001_0000;
    endfunction

    function automatic logic [63:0] m_prod(input logic [31:0] a, input logic [31:0] b,
                                           input bit sgn);
        longint sa, sb;
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    task automatic m_apply(input int op, input logic [31:0] a, input logic [31:0] b,
                           input int e);
        logic [63:0] p;
        bit sgn, nar;
        case (op)
            0, 1, 2, 3, 4, 5: begin
                sgn = (op % 2) == 0;
                p   = m_prod(a, b, sgn);
                nar = m_narrow(b, sgn);
                if (op < 2)      m_acc = p;
                else if (op < 4) m_acc = m_acc + p;
                else             m_acc = m_acc - p;
                if (nar) exp_done[e] = 1'b1;
                else begin
                    exp_done[e+1] = 1'b1;
                    block_edge    = e + 1;
                    pend_edge     = e + 1;
                end
            end
            6: begin
                p   = m_prod(a, b, 1'b1);
                nar = m_narrow(b, 1'b1);
                if (nar) begin
                    exp_done[e+1] = 1'b1; exp_rd[e+1] = p[31:0]; pend_edge = e + 1;
                end else begin
                    exp_done[e+2] = 1'b1; exp_rd[e+2] = p[31:0]; pend_edge = e + 2;
                    block_edge = e + 1;
                end
            end
            8:  exp_rd[e] = m_acc[63:32];
            9:  exp_rd[e] = m_acc[31:0];
            10: m_acc[63:32] = a;
            11: m_acc[31:0]  = a;
            default: ;
        endcase
    endtask

    // Advance one edge and compare all outputs against the model
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, "done", done, exp_done.exists(edge_n));
        chk(cur_req, "rd_valid", rd_valid, exp_rd.exists(edge_n));
        if (exp_rd.exists(edge_n)) chk(cur_req, "rd_data", rd_data, exp_rd[edge_n]);
        chk("R7/R8 busy", "busy", busy, block_edge == edge_n + 1);
        edge_n++;
    endtask

    task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b);
        bit ok;
        issue_valid = 1'b1;
        issue_op    = 4'(op);
        rs_val      = a;
        rt_val      = b;
        forever begin
            ok = (block_edge != edge_n) && !((op == 8 || op == 9) && pend_edge >= edge_n);
            #1;
            chk("R9", "issue_ready", issue_ready, ok);
            if (ok) m_apply(op, a, b, edge_n);
            tick();
            if (ok) break;
        end
        issue_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic read_both();
        issue(8, 0, 0);
        issue(9, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        n_chk = 0; n_err = 0; m_acc = '0; edge_n = 0;
        block_edge = -10; pend_edge = -10;
        cur_req = "R10";
        rst = 1'b1; issue_valid = 1'b0; issue_op = '0; rs_val = '0; rt_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10", "busy", busy, 0);
        chk("R10", "done", done, 0);
        chk("R10", "rd_valid", rd_valid, 0);
        read_both();

        // R1: replace accumulator, signed and unsigned
        cur_req = "R1";
        issue(0, 32'hFFFF_FFFB, 32'd7);      read_both();
        issue(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); read_both();
        issue(0, 32'h8000_0000, 32'h8000_0000); read_both();

        // R2: accumulate add/subtract, with wrap
        cur_req = "R2";
        issue(0, 32'd3, 32'd4);
        issue(2, 32'hFFFF_FFFE, 32'd5);      read_both();
        issue(3, 32'hFFFF_FFFF, 32'h0001_0000); read_both();
        issue(1, 32'd0, 32'd0);
        issue(5, 32'd1, 32'd1);              read_both();
        issue(4, 32'h1234_5678, 32'h9ABC_DEF0); read_both();

        // R5: direct writes to HI and LO
        cur_req = "R5";
        issue(10, 32'hCAFE_0001, 0);         read_both();
        issue(11, 32'h0BAD_F00D, 0);         read_both();

        // R3 and R8: register-destination multiply, HI/LO untouched
        cur_req = "R3";
        issue(6, 32'hFFFF_FFF0, 32'd9);
        issue(6, 32'h0001_0001, 32'h1234_5678);
        issue(6, 32'd5, 32'hFFFF_FFFF);
        read_both();
        // R9: read offered immediately behind a long multiply stalls
        cur_req = "R9";
        issue(6, 32'h7777_7777, 32'h0010_0000);
        issue(8, 0, 0);
        issue(6, 32'd11, 32'd13);
        issue(9, 0, 0);

        // R6: classification edges observed through done timing
        cur_req = "R6";
        issue(0, 32'd2, 32'h0000_7FFF); idle(1);
        issue(0, 32'd2, 32'h0000_8000); idle(1);
        issue(1, 32'd2, 32'h0000_8000); idle(1);
        issue(1, 32'd2, 32'h0001_0000); idle(1);
        issue(0, 32'd2, 32'hFFFF_8000); idle(1);
        issue(0, 32'd2, 32'hFFFF_7FFF); idle(1);
        issue(6, 32'd2, 32'hFFFF_8000);
        issue(6, 32'd2, 32'h0000_8000); idle(3);

        // R11: reserved codes have no effect
        cur_req = "R11";
        issue(1, 32'h0000_1111, 32'h0000_2222);
        issue(7, 32'hDEAD_BEEF, 32'h1);
        issue(12, 32'hDEAD_BEEF, 32'h1);
        issue(15, 32'hDEAD_BEEF, 32'h1);
        read_both();

        // R4 and R7: random mix of everything
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [31:0] a, b;
            op = $urandom_range(0, 15);
            a  = $urandom;
            case ($urandom_range(0, 3))
                0: b = $urandom_range(0, 32767);
                1: b = 32'hFFFF_0000 | 32'($urandom_range(32768, 65535));
                2: b = 32'($urandom_range(32768, 65535));
                default: b = $urandom;
            endcase
            issue(op, a, b);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
            if ($urandom_range(0, 4) == 0) read_both();
        end
        cur_req = "R7";
        idle(4);
        read_both();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule